// File: doc/BRIEF.md
# Dual-Frequency Phase Accumulator NCO

This block is the phase engine of a direct digital synthesizer. It keeps two frequency tuning words and a phase offset word in registers. Every clock it adds one of the two tuning words to a phase accumulator that wraps around. The output frequency is the tuning word read as a binary fraction of the clock rate: fout = word × fclk / 2^ACC_W. The offset is added to the accumulated phase. The top bits of that sum form the phase word that a later sine lookup stage consumes.

A select input picks which tuning word is added. It may change on any cycle. Because the select is registered before use, a switch lands cleanly on an accumulation boundary. This suits frequency-shift keying at full clock rate.

The block sleeps when either a sleep pin or a registered sleep command bit is high. While asleep the accumulator and the held words stay frozen. Counting resumes from the frozen value once sleep is released.

Top module: `nco_dual_freq`

## Requirements
- R1: While `rst_i` is high, both tuning words, the phase offset, the select register, the sleep command bit and the accumulator are all cleared to zero, so `phase_o` reads 0. This holds even when the data inputs are nonzero.
- R2: On each awake rising edge, the tuning-word and offset registers capture `freq0_i`, `freq1_i` and `poff_i`. On the same edge the accumulator adds the tuning word that was already held (the captured word takes part from the next edge on).
- R3: `fsel_i` is registered once, with 0 selecting word 0 and 1 selecting word 1. A change applied before edge N changes the added word from edge N+1 on.
- R4: `phase_o` is bits [ACC_W-1:ACC_W-OUT_W] (the upper 12 bits by default) of (accumulator + held phase offset) mod 2^ACC_W.
- R5: While `sleep_pin_i` is high, the accumulator, the tuning words, the offset and the select register hold their values, and `phase_o` stays constant. Counting resumes from the held value on release.
- R6: `sleep_cmd_i` is captured into a command bit on every edge, including edges that occur while asleep. When that bit is 1, the block sleeps exactly as in R5. Sleep is the OR of the pin and the bit.
- R7: The accumulator wraps modulo 2^ACC_W. A word of 2^(ACC_W-1) makes the top output bit toggle each cycle, and a word of all ones steps the phase backwards by one LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| freq0_i | input | ACC_W | Tuning word 0 |
| freq1_i | input | ACC_W | Tuning word 1 |
| poff_i | input | ACC_W | Phase offset word |
| fsel_i | input | 1 | Tuning word select (0: word 0, 1: word 1) |
| sleep_pin_i | input | 1 | Sleep request from pin, active high |
| sleep_cmd_i | input | 1 | Sleep command bit value, active high |
| phase_o | output | OUT_W | Truncated phase for sine lookup |

## Verification
The accumulation is tried with the following stimulus:
- Each tuning word alone, which separates the two word paths.
- A nonzero offset, which shows whether the offset reaches the output without disturbing the accumulator.
- Select toggles on single cycles, which expose a missing or doubled select register.
- A half-scale word and an all-ones word, which tell a correct modulo wrap from a saturating or sign-extended one.

Sleep is driven separately from the pin and from the command bit, with the word inputs changing during sleep. This shows that both sources freeze the state and that counting resumes from the held phase. A reset in mid-run, with nonzero inputs, shows that every register is cleared.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int DEF_ACC_W = 32;
    localparam int DEF_OUT_W = 12;

    typedef enum logic {
        SEL_WORD0 = 1'b0,
        SEL_WORD1 = 1'b1
    } word_sel_e;
endpackage

// File: rtl/nco_word_bank.sv
module nco_word_bank
    import nco_pkg::*;
#(
    parameter int ACC_W = DEF_ACC_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             hold_i,
    input  logic [ACC_W-1:0] freq0_i,
    input  logic [ACC_W-1:0] freq1_i,
    input  logic [ACC_W-1:0] poff_i,
    input  logic             fsel_i,
    input  logic             sleep_cmd_i,
    output logic [ACC_W-1:0] step_o,
    output logic [ACC_W-1:0] poff_o,
    output logic             cmd_sleep_o
);
    typedef struct packed {
        logic [ACC_W-1:0] f0;
        logic [ACC_W-1:0] f1;
        logic [ACC_W-1:0] poff;
        word_sel_e        sel;
        logic             cmd;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cmd = sleep_cmd_i;
        if (!hold_i) begin
            s_d.f0   = freq0_i;
            s_d.f1   = freq1_i;
            s_d.poff = poff_i;
            s_d.sel  = fsel_i ? SEL_WORD1 : SEL_WORD0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign step_o      = (s_q.sel == SEL_WORD1) ? s_q.f1 : s_q.f0;
    assign poff_o      = s_q.poff;
    assign cmd_sleep_o = s_q.cmd;

    // R3: select takes the input value one edge later when awake
    assert_sel_latency_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !hold_i |=> (s_q.sel == word_sel_e'($past(fsel_i))));

    // R6: command bit follows its input on every edge
    assert_cmd_capture_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (cmd_sleep_o == $past(sleep_cmd_i)));

    // R5: held words do not move while asleep
    assert_words_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_i |=> ($stable(step_o) && $stable(poff_o)));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
    import nco_pkg::*;
#(
    parameter int ACC_W = DEF_ACC_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             hold_i,
    input  logic [ACC_W-1:0] step_i,
    output logic [ACC_W-1:0] acc_o
);
    logic [ACC_W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (!hold_i) begin
            acc_d = acc_q + step_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc_o = acc_q;

    // R2, R7: awake edge advances by the held step, modulo 2^ACC_W
    assert_step_wrap_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !hold_i |=> (acc_o == ACC_W'($past(acc_o) + $past(step_i))));

    // R5: frozen while asleep
    assert_acc_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_i |=> $stable(acc_o));
endmodule

// File: rtl/nco_phase_out.sv
module nco_phase_out
    import nco_pkg::*;
#(
    parameter int ACC_W = DEF_ACC_W,
    parameter int OUT_W = DEF_OUT_W
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] poff_i,
    output logic [OUT_W-1:0] phase_o
);
    localparam int LSB = ACC_W - OUT_W;

    logic [ACC_W-1:0] sum;

    always_comb begin
        sum     = acc_i + poff_i;
        phase_o = sum[ACC_W-1:LSB];
    end
endmodule

// File: rtl/nco_dual_freq.sv
module nco_dual_freq
    import nco_pkg::*;
#(
    parameter int ACC_W = DEF_ACC_W,
    parameter int OUT_W = DEF_OUT_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [ACC_W-1:0] freq0_i,
    input  logic [ACC_W-1:0] freq1_i,
    input  logic [ACC_W-1:0] poff_i,
    input  logic             fsel_i,
    input  logic             sleep_pin_i,
    input  logic             sleep_cmd_i,
    output logic [OUT_W-1:0] phase_o
);
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] poff_q;
    logic [ACC_W-1:0] acc;
    logic             cmd_sleep;
    logic             asleep;

    assign asleep = sleep_pin_i | cmd_sleep;

    nco_word_bank #(.ACC_W(ACC_W)) u_bank (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .hold_i      (asleep),
        .freq0_i     (freq0_i),
        .freq1_i     (freq1_i),
        .poff_i      (poff_i),
        .fsel_i      (fsel_i),
        .sleep_cmd_i (sleep_cmd_i),
        .step_o      (step),
        .poff_o      (poff_q),
        .cmd_sleep_o (cmd_sleep)
    );

    nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .hold_i (asleep),
        .step_i (step),
        .acc_o  (acc)
    );

    nco_phase_out #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_out (
        .acc_i   (acc),
        .poff_i  (poff_q),
        .phase_o (phase_o)
    );

    // R5: sleep pin keeps the output phase still
    assert_pin_freeze_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        sleep_pin_i |=> $stable(phase_o));

    // R6: command sleep bit keeps the output phase still
    assert_cmd_freeze_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_sleep |=> $stable(phase_o));

    // R1: first cycle out of reset starts from a cleared state
    assert_reset_clear_R1: assert property (@(posedge clk_i)
        rst_i |=> (rst_i || (acc == '0 && poff_q == '0 && phase_o == '0)));
endmodule

// File: tb/sim_nco_dual_freq.sv
module sim_nco_dual_freq;
    localparam int ACC_W = 32;
    localparam int OUT_W = 12;

    typedef struct packed {
        logic [31:0] f0;
        logic [31:0] f1;
        logic [31:0] ph;
        logic        sel;
        logic        spin;
        logic        scmd;
        logic [7:0]  cyc;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h0100_0000, 32'h0040_0000, 32'h0, 1'b0, 1'b0, 1'b0, 8'd6, 8'd2}, // R2 word 0
        '{32'h0100_0000, 32'h0040_0000, 32'h0, 1'b1, 1'b0, 1'b0, 8'd5, 8'd3}, // R3 word 1
        '{32'h0100_0000, 32'h0040_0000, 32'h4000_0000, 1'b0, 1'b0, 1'b0, 8'd4, 8'd4}, // R4 offset
        '{32'h0300_0000, 32'h0040_0000, 32'h1234_5678, 1'b1, 1'b1, 1'b0, 8'd4, 8'd5}, // R5 pin sleep
        '{32'h0300_0000, 32'h0040_0000, 32'h1234_5678, 1'b0, 1'b0, 1'b0, 8'd3, 8'd5}, // R5 resume
        '{32'h0700_0000, 32'h0800_0000, 32'h0, 1'b1, 1'b0, 1'b1, 8'd4, 8'd6}, // R6 cmd sleep
        '{32'h0700_0000, 32'h0800_0000, 32'h0, 1'b1, 1'b0, 1'b0, 8'd3, 8'd6}, // R6 resume
        '{32'h0700_0000, 32'h0800_0000, 32'h0, 1'b0, 1'b0, 1'b0, 8'd1, 8'd3}, // R3 single-cycle toggle
        '{32'h0700_0000, 32'h0800_0000, 32'h0, 1'b1, 1'b0, 1'b0, 8'd1, 8'd3}, // R3 single-cycle toggle
        '{32'hFFFF_FFFF, 32'h8000_0000, 32'h0, 1'b0, 1'b0, 1'b0, 8'd5, 8'd7}  // R7 wrap
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [ACC_W-1:0] f0 = '0, f1 = '0, ph = '0;
    logic             sel = 1'b0, spin = 1'b0, scmd = 1'b0;
    logic [OUT_W-1:0] phase;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    nco_dual_freq #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u0 (
        .clk_i(clk), .rst_i(rst), .freq0_i(f0), .freq1_i(f1), .poff_i(ph),
        .fsel_i(sel), .sleep_pin_i(spin), .sleep_cmd_i(scmd), .phase_o(phase)
    );

    // reference behaviour built from the requirements
    logic [31:0] m_f0, m_f1, m_ph, m_acc;
    logic        m_sel, m_cmd;
    always @(posedge clk) begin
        if (rst) begin
            m_f0 <= '0; m_f1 <= '0; m_ph <= '0; m_acc <= '0;
            m_sel <= 1'b0; m_cmd <= 1'b0;
        end else begin
            m_cmd <= scmd;
            if (!(spin || m_cmd)) begin
                m_f0  <= f0; m_f1 <= f1; m_ph <= ph; m_sel <= sel;
                m_acc <= m_acc + (m_sel ? m_f1 : m_f0);
            end
        end
    end

    function automatic logic [11:0] model_phase();
        logic [31:0] s;
        s = m_acc + m_ph;
        return s[31:20];
    endfunction

    task automatic check(input string req, input logic [11:0] exp);
        n_chk++;
        if (phase !== exp) begin
            n_bad++;
            $display("FAIL %s: phase_o=%03h expected=%03h at %0t", req, phase, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        f0 = 32'hDEAD_BEEF; ph = 32'h5555_5555;
        repeat (3) tick();
        check("R1", 12'h000);
        rst = 1'b0;
        f0 = '0; ph = '0;
        tick();
        check("R1", 12'h000);

        // table walk against the requirement model
        foreach (VECS[i]) begin
            f0 = VECS[i].f0; f1 = VECS[i].f1; ph = VECS[i].ph;
            sel = VECS[i].sel; spin = VECS[i].spin; scmd = VECS[i].scmd;
            for (int c = 0; c < int'(VECS[i].cyc); c++) begin
                tick();
                check($sformatf("R%0d", VECS[i].req), model_phase());
            end
        end

        // R1: reset in mid-run clears all, with nonzero inputs held
        rst = 1'b1;
        tick();
        check("R1", 12'h000);
        rst = 1'b0;
        f0 = 32'h8000_0000; f1 = 32'h0; ph = 32'h0; sel = 1'b0; spin = 1'b0; scmd = 1'b0;

        // R7: half-scale word toggles the top bit
        tick();                    // word captured, acc += 0
        check("R7", 12'h000);
        tick();                    // acc = 0x80000000
        check("R7", 12'h800);
        tick();                    // wrapped to 0
        check("R7", 12'h000);

        // R3: select latency with word0 = 0, word1 = one output LSB
        f0 = 32'h0; f1 = 32'h0010_0000;
        tick();                    // acc += 0x80000000 -> 0x80000000
        check("R3", 12'h800);
        tick();                    // acc += 0 (f0 now zero)
        check("R3", 12'h800);
        sel = 1'b1;
        tick();                    // sel captured, still adds word 0
        check("R3", 12'h800);
        tick();                    // word 1 added
        check("R3", 12'h801);
        sel = 1'b0;
        tick();                    // registered select still 1
        check("R3", 12'h802);
        tick();
        check("R3", 12'h802);

        // R4: offset of half scale flips the top bit, accumulator untouched
        ph = 32'h8000_0000;
        tick();
        check("R4", 12'h002);
        ph = 32'h0;
        tick();
        check("R4", 12'h802);

        // R5: sleep pin with changing inputs, then resume from held value
        spin = 1'b1; sel = 1'b1; f1 = 32'h0100_0000; ph = 32'h4000_0000;
        repeat (3) begin
            tick();
            check("R5", 12'h802);
        end
        spin = 1'b0;
        tick();                    // words captured, held step 0 added
        check("R5", 12'hC02);
        tick();                    // word 1 (0x01000000) added
        check("R5", 12'hC12);

        // R6: command bit sleeps one edge after it is set
        scmd = 1'b1;
        tick();                    // bit captured, this edge still counts
        check("R6", 12'hC22);
        tick();
        check("R6", 12'hC22);
        scmd = 1'b0;
        tick();                    // bit cleared, edge still held
        check("R6", 12'hC22);
        tick();
        check("R6", 12'hC32);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule